// File: doc/BRIEF.md
# Hub Status-Change Interrupt Endpoint

This block keeps the change bitmap that a hub reports on its interrupt endpoint, and it answers each IN token on that endpoint. Once per frame, at the end-of-frame marker, it samples one change flag for the hub and one for each downstream port. Every flag sampled as set is added to a sticky bitmap. A bit leaves the bitmap only when the host clears it with a clear request. If nothing has changed, the host gets a NAK. If any change is pending, the host gets the whole bitmap byte.

The block also holds the four-bit control status register: configured, remote-wakeup enabled, default endpoint stalled, and interrupt endpoint stalled. No change is reported while the hub is unconfigured. A stalled interrupt endpoint answers every token with STALL.

IN tokens enter on a valid/ready handshake and responses leave on a second one. A token is accepted only when no response is waiting. The response appears in the cycle after the token is accepted. It stays on the bus, unchanged, until the consumer raises `resp_ready`.

Top module: `hub_chg_ep`

## Requirements
- R1: Bitmap bits are set only at a rising clock edge where `frame_end` is high. At that edge, each set bit of the change vector `{port_chg, hub_chg}` is latched. Flags that are high between markers are not captured.
- R2: In `resp_data`, bit 0 carries the hub change and bits 1 to 4 carry the changes of ports 1 to 4. Bits 5 to 7 always read 0.
- R3: When the hub is configured and endpoint 1 is not stalled, an IN token against an empty bitmap is answered with `resp_code` 2'b00 (NAK).
- R4: When the hub is configured, endpoint 1 is not stalled and any bitmap bit is set, the answer is `resp_code` 2'b01 (DATA) together with the whole bitmap byte.
- R5: A latched bit stays set across any number of polls and frames until a `clr_mask` pulse hits the same bit position. If a clear and a sampled flag hit the same bit in the same cycle, the bit stays set.
- R6: While control bit 0 (configured) is 0, every IN token is answered with NAK. Latched bits are kept while the hub is deconfigured, and they are reported again once the hub is configured.
- R7: `csr` bit 0 is configured, bit 1 is remote-wakeup enabled, bit 2 is endpoint 0 stalled and bit 3 is endpoint 1 stalled. All four bits are 0 after reset. Each bit is loaded from its own `*_val` input when its `*_wr` strobe is high.
- R8: While `csr` bit 3 is set, every IN token is answered with `resp_code` 2'b10 (STALL), whatever the bitmap holds and whether or not the hub is configured.
- R9: `in_ready` equals `!resp_valid`. An accepted token raises `resp_valid` in the next cycle. `resp_code` and `resp_data` hold steady while `resp_valid && !resp_ready`. The response drops after the cycle in which `resp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | End-of-frame sampling strobe |
| hub_chg | input | 1 | Hub-level change flag |
| port_chg | input | NPORTS | Per-port change flags, bit 0 = port 1 |
| clr_mask | input | NPORTS+1 | One-cycle clear pulses, one per bitmap bit |
| cfg_wr | input | 1 | Load configured bit |
| cfg_val | input | 1 | Value for configured bit |
| wake_wr | input | 1 | Load remote-wakeup bit |
| wake_val | input | 1 | Value for remote-wakeup bit |
| stall0_wr | input | 1 | Load endpoint 0 stall bit |
| stall0_val | input | 1 | Value for endpoint 0 stall bit |
| stall1_wr | input | 1 | Load endpoint 1 stall bit |
| stall1_val | input | 1 | Value for endpoint 1 stall bit |
| in_valid | input | 1 | IN token present |
| in_ready | output | 1 | Token can be accepted |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_code | output | 2 | 00 NAK, 01 DATA, 10 STALL |
| resp_data | output | 8 | Bitmap byte sent with DATA |
| csr | output | 4 | Control status register |

## Verification
The assertions check several rules on every cycle. A bitmap bit rises only at a sampling edge where its flag was set, and it never falls without a clear. The reserved bits stay 0, and a DATA answer never carries an empty byte. A held response stays frozen under back-pressure, and STALL and NAK are chosen correctly from the control bits. Other behaviour only the bench's scenarios can show. These include the sweep of every flag pattern through sampling, polling and clearing; flags that are ignored between markers; a deconfigure followed by a reconfigure that brings the latched bits back; and a clear colliding with a new sample on the same bit.

// File: rtl/hub_chg_pkg.sv
package hub_chg_pkg;

  typedef enum logic [1:0] {
    RSP_NAK   = 2'b00,
    RSP_DATA  = 2'b01,
    RSP_STALL = 2'b10
  } rsp_e;

  localparam int CSR_W    = 4;
  localparam int CSR_CFG  = 0;
  localparam int CSR_WAKE = 1;
  localparam int CSR_STL0 = 2;
  localparam int CSR_STL1 = 3;

endpackage

// File: rtl/hub_chg_csr.sv
module hub_chg_csr
  import hub_chg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_val,
  input  logic             wake_wr,
  input  logic             wake_val,
  input  logic             stall0_wr,
  input  logic             stall0_val,
  input  logic             stall1_wr,
  input  logic             stall1_val,
  output logic [CSR_W-1:0] csr_q
);

  logic [CSR_W-1:0] wr_vec;
  logic [CSR_W-1:0] val_vec;

  always_comb begin
    wr_vec            = '0;
    val_vec           = '0;
    wr_vec[CSR_CFG]   = cfg_wr;
    val_vec[CSR_CFG]  = cfg_val;
    wr_vec[CSR_WAKE]  = wake_wr;
    val_vec[CSR_WAKE] = wake_val;
    wr_vec[CSR_STL0]  = stall0_wr;
    val_vec[CSR_STL0] = stall0_val;
    wr_vec[CSR_STL1]  = stall1_wr;
    val_vec[CSR_STL1] = stall1_val;
  end

  for (genvar b = 0; b < CSR_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)         csr_q[b] <= 1'b0;
      else if (wr_vec[b]) csr_q[b] <= val_vec[b];
    end

    AST_CSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vec[b] |=> $stable(csr_q[b])); // R7
  end

endmodule

// File: rtl/hub_chg_bitmap.sv
module hub_chg_bitmap #(
  parameter int NFLAG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] bmp_q
);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                      bmp_q[i] <= 1'b0;
      else if (frame_end && flags[i])  bmp_q[i] <= 1'b1;
      else if (clr[i])                 bmp_q[i] <= 1'b0;
    end

    AST_SET_AT_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bmp_q[i]) |-> $past(frame_end && flags[i])); // R1
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (bmp_q[i] && !clr[i]) |=> bmp_q[i]); // R5
  end

endmodule

// File: rtl/hub_chg_resp.sv
module hub_chg_resp
  import hub_chg_pkg::*;
#(
  parameter int NFLAG = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  bmp,
  input  logic              configured,
  input  logic              ep1_stalled,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              resp_valid,
  input  logic              resp_ready,
  output rsp_e              resp_code,
  output logic [BYTE_W-1:0] resp_data
);

  localparam int PAD_W = BYTE_W - NFLAG;

  logic accept;
  rsp_e pick;

  assign in_ready = !resp_valid;
  assign accept   = in_valid && !resp_valid;

  always_comb begin
    if (ep1_stalled)                  pick = RSP_STALL;
    else if (!configured || bmp == '0) pick = RSP_NAK;
    else                              pick = RSP_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= RSP_NAK;
      resp_data  <= '0;
    end else if (accept) begin
      resp_valid <= 1'b1;
      resp_code  <= pick;
      resp_data  <= (pick == RSP_DATA) ? {{PAD_W{1'b0}}, bmp} : '0;
    end else if (resp_valid && resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_data[BYTE_W-1:NFLAG] == '0); // R2
  AST_DATA_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == RSP_DATA) |-> resp_data != '0); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_code) && $stable(resp_data))); // R9
  AST_STALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ep1_stalled) |=> resp_code == RSP_STALL); // R8
  AST_UNCFG_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !configured && !ep1_stalled) |=> resp_code == RSP_NAK); // R6
  AST_EMPTY_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bmp == '0 && !ep1_stalled) |=> resp_code == RSP_NAK); // R3

endmodule

// File: rtl/hub_chg_ep.sv
module hub_chg_ep
  import hub_chg_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int NFLAG  = NPORTS + 1,
  parameter int BYTE_W = ((NFLAG + 7) / 8) * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              hub_chg,
  input  logic [NPORTS-1:0] port_chg,
  input  logic [NFLAG-1:0]  clr_mask,
  input  logic              cfg_wr,
  input  logic              cfg_val,
  input  logic              wake_wr,
  input  logic              wake_val,
  input  logic              stall0_wr,
  input  logic              stall0_val,
  input  logic              stall1_wr,
  input  logic              stall1_val,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [1:0]        resp_code,
  output logic [BYTE_W-1:0] resp_data,
  output logic [CSR_W-1:0]  csr
);

  logic [NFLAG-1:0] chg_vec;
  logic [NFLAG-1:0] bmp;
  rsp_e             code_e;

  assign chg_vec   = {port_chg, hub_chg};
  assign resp_code = code_e;

  hub_chg_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_val    (cfg_val),
    .wake_wr    (wake_wr),
    .wake_val   (wake_val),
    .stall0_wr  (stall0_wr),
    .stall0_val (stall0_val),
    .stall1_wr  (stall1_wr),
    .stall1_val (stall1_val),
    .csr_q      (csr)
  );

  hub_chg_bitmap #(.NFLAG(NFLAG)) u_bmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .flags     (chg_vec),
    .clr       (clr_mask),
    .bmp_q     (bmp)
  );

  hub_chg_resp #(.NFLAG(NFLAG), .BYTE_W(BYTE_W)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .bmp         (bmp),
    .configured  (csr[CSR_CFG]),
    .ep1_stalled (csr[CSR_STL1]),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .resp_valid  (resp_valid),
    .resp_ready  (resp_ready),
    .resp_code   (code_e),
    .resp_data   (resp_data)
  );

  AST_READY_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !resp_valid); // R9

endmodule

// File: tb/hub_chg_ep_bench.sv
module hub_chg_ep_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_end = 0, hub_chg = 0;
  logic [3:0] port_chg = '0;
  logic [4:0] clr_mask = '0;
  logic       cfg_wr = 0, cfg_val = 0, wake_wr = 0, wake_val = 0;
  logic       stall0_wr = 0, stall0_val = 0, stall1_wr = 0, stall1_val = 0;
  logic       in_valid = 0, resp_ready = 0;
  logic       in_ready, resp_valid;
  logic [1:0] resp_code;
  logic [7:0] resp_data;
  logic [3:0] csr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hub_chg_ep u_hub_chg_ep (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .hub_chg(hub_chg),
    .port_chg(port_chg), .clr_mask(clr_mask), .cfg_wr(cfg_wr), .cfg_val(cfg_val),
    .wake_wr(wake_wr), .wake_val(wake_val), .stall0_wr(stall0_wr),
    .stall0_val(stall0_val), .stall1_wr(stall1_wr), .stall1_val(stall1_val),
    .in_valid(in_valid), .in_ready(in_ready), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_code(resp_code), .resp_data(resp_data),
    .csr(csr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [4:0] f);
    {port_chg, hub_chg} = f;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    {port_chg, hub_chg} = '0;
  endtask

  task automatic clear(input logic [4:0] m);
    clr_mask = m;
    @(negedge clk);
    clr_mask = '0;
  endtask

  task automatic wr_csr(input int idx, input logic v);
    case (idx)
      0: begin cfg_wr = 1; cfg_val = v; end
      1: begin wake_wr = 1; wake_val = v; end
      2: begin stall0_wr = 1; stall0_val = v; end
      default: begin stall1_wr = 1; stall1_val = v; end
    endcase
    @(negedge clk);
    {cfg_wr, wake_wr, stall0_wr, stall1_wr} = '0;
  endtask

  task automatic poll(input string req, input logic [1:0] ecode, input logic [7:0] edata);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(resp_valid == 1'b1, {req, " valid"}, resp_valid, 1);
    check(resp_code == ecode, {req, " code"}, resp_code, ecode);
    if (ecode == 2'b01) check(resp_data == edata, {req, " data"}, resp_data, edata);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(resp_valid == 0, "R9 reset valid", resp_valid, 0);
    check(in_ready == 1, "R9 reset ready", in_ready, 1);
    check(csr == 4'h0, "R7 reset csr", csr, 0);

    // R6: unconfigured hub answers NAK even with latched changes
    frame(5'b00011);
    poll("R6 unconfigured", 2'b00, 8'h00);
    wr_csr(0, 1'b1);
    check(csr == 4'h1, "R7 configured bit", csr, 1);
    // R6: latched bits reported after configuring
    poll("R6 after config", 2'b01, 8'h03);
    clear(5'b11111);

    // R2 R3 R4 R5: sweep of every flag pattern
    for (int p = 0; p < 32; p++) begin
      frame(p[4:0]);
      poll("R4 sweep", (p != 0) ? 2'b01 : 2'b00, {3'b000, p[4:0]});
      repeat (2) @(negedge clk);
      poll("R5 persists", (p != 0) ? 2'b01 : 2'b00, {3'b000, p[4:0]});
      clear(5'b11111);
      poll("R3 empty after clear", 2'b00, 8'h00);
    end

    // R1: flags between markers are not captured
    {port_chg, hub_chg} = 5'b11111;
    repeat (4) @(negedge clk);
    {port_chg, hub_chg} = '0;
    poll("R1 mid-frame", 2'b00, 8'h00);

    // R5: partial clear, and clear colliding with a sample
    frame(5'b10101);
    clear(5'b00001);
    poll("R5 partial clear", 2'b01, 8'h14);
    {port_chg, hub_chg} = 5'b00100;
    frame_end = 1'b1;
    clr_mask = 5'b00100;
    @(negedge clk);
    frame_end = 0; clr_mask = '0; {port_chg, hub_chg} = '0;
    poll("R5 sample beats clear", 2'b01, 8'h14);

    // R8: stalled endpoint 1
    wr_csr(3, 1'b1);
    check(csr == 4'b1001, "R7 stall1 bit", csr, 9);
    poll("R8 stall", 2'b10, 8'h00);
    wr_csr(0, 1'b0);
    poll("R8 stall unconfigured", 2'b10, 8'h00);
    wr_csr(3, 1'b0);

    // R6: deconfigured keeps bits
    poll("R6 deconfigured", 2'b00, 8'h00);
    wr_csr(0, 1'b1);
    poll("R6 bits kept", 2'b01, 8'h14);

    // R7: remaining bits
    wr_csr(1, 1'b1);
    wr_csr(2, 1'b1);
    check(csr == 4'b0111, "R7 wake+stall0", csr, 7);
    poll("R7 stall0 no effect", 2'b01, 8'h14);

    // R9: back-pressure
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 0, "R9 busy ready", in_ready, 0);
    frame(5'b01000);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(resp_valid && resp_data == 8'h14, "R9 held data", resp_data, 8'h14);
    check(in_ready == 0, "R9 blocked", in_ready, 0);
    in_valid = 1'b0;
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    check(resp_valid == 0, "R9 drained", resp_valid, 0);
    poll("R9 next token", 2'b01, 8'h1C);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule